// File: doc/BRIEF.md
# Cascaded Prescaler Interval Timer

This block is a time base that runs from the bus clock. A bank of 8-bit prescaler stages (micro timers) each count down and fire a tick when they reach zero. A set of 16-bit modulus channels each listen to one chosen micro timer and step down once per tick of that timer. When a channel runs out, it reloads, latches a time-out flag and drives a single-cycle trigger. The interval in bus clocks is therefore (prescaler load + 1) × (channel load + 1).

Software uses a small word-wide register bus. Through it, software sets the load values, enables counting, routes each channel to a micro timer, restarts any mix of micro timers and channels in a single write, clears flags and reads back the live channel counts. The prescaler counts cannot be read.

Register map (word addresses): 0x00 control (bit 0 global run), 0x01 channel enables (bit c), 0x02 micro timer select (bit c: 0 = micro timer 0, 1 = micro timer 1), 0x03 restart strobes, 0x04 time-out flags (bit c), 0x08+m micro timer m load, 0x10+c channel c load, 0x18+c channel c count (read only).

Top module: `cascade_timer`

## Requirements
- R1: With global run and the channel enabled, the channel's trigger repeats every (Lm + 1) × (Lc + 1) bus clocks. Lm is the load of its selected micro timer and Lc is the channel load. This holds when either load is 0.
- R2: A channel is clocked only by the micro timer named in its select bit at 0x02 (0 selects micro timer 0, 1 selects micro timer 1). The load of the other micro timer does not change its interval.
- R3: Reading 0x18+c returns channel c's live count. The count steps down once per tick of its micro timer and goes back to its load value on the edge where it would pass below zero.
- R4: A time-out drives trig_o[c] high for the single cycle that follows the time-out edge. The flag in 0x04 bit c is set on that same edge, and the trigger is low again in the next cycle when the interval is longer than one clock.
- R5: Writing 1 to bit c of 0x04 clears that flag. Writing 0 to the bit leaves the flag as it is.
- R6: If a flag clear and a time-out of the same channel fall on one edge, the flag is left set.
- R7: Writing 1 to bit c of 0x03 (bits 7:0 are the channel restart bits) loads channel c's count from its load value on that edge. If the micro timers are restarted in the same write, the next trigger comes a full interval after the restart.
- R8: Writing 1 to bit 8+m of 0x03 restarts micro timer m from its load value. Bits of both stages may be set together in one write, and all of them take effect on the same edge.
- R9: Reading 0x03 always returns 0.
- R10: While the global run bit (0x00 bit 0) is 0, or while a channel's enable bit is 0, that channel keeps its count and raises no trigger or flag. Enabled channels keep counting.
- R11: After reset, all counts, loads, flags, enables and triggers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| trig_o | output | 4 | Per-channel time-out trigger pulses |

## Verification
Two pairs of functions can fall on the same edge. The first is a software flag clear together with a hardware time-out. The second is a restart strobe together with the count step it pre-empts. The first pair is provoked by running a channel with both loads at 0, which makes every edge a time-out, and then writing the clear: the flag must still read as set. The second pair is provoked by restarts written partway through an interval, once for both stages and once for the prescaler alone. The bench judges each by counting clocks to the next trigger against the interval formula.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
  localparam int ADDR_W = 5;
  localparam int BUS_W  = 16;
  localparam int FORCE_MT_LSB = 8;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] A_CH_EN   = 5'h01;
  localparam logic [ADDR_W-1:0] A_MT_SEL  = 5'h02;
  localparam logic [ADDR_W-1:0] A_FORCE   = 5'h03;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 5'h04;
  localparam logic [ADDR_W-1:0] A_MT_LOAD = 5'h08;
  localparam logic [ADDR_W-1:0] A_CH_LOAD = 5'h10;
  localparam logic [ADDR_W-1:0] A_CH_CNT  = 5'h18;
endpackage

// File: rtl/ct_regs.sv
module ct_regs
  import cascade_timer_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int N_MT  = 2,
  parameter int MT_W  = 8,
  parameter int CNT_W = 16,
  localparam int SEL_W = (N_MT > 1) ? $clog2(N_MT) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [BUS_W-1:0]                  wdata,
  output logic [BUS_W-1:0]                  rdata,
  output logic                              gen_en,
  output logic [N_CH-1:0]                   ch_en,
  output logic [N_CH-1:0][SEL_W-1:0]        ch_sel,
  output logic [N_MT-1:0][MT_W-1:0]         mt_load,
  output logic [N_CH-1:0][CNT_W-1:0]        ch_load,
  output logic [N_MT-1:0]                   mt_force,
  output logic [N_CH-1:0]                   ch_force,
  output logic [N_CH-1:0]                   flag_clr,
  input  logic [N_CH-1:0]                   flags,
  input  logic [N_CH-1:0][CNT_W-1:0]        ch_cnt
);
  logic                       gen_q, gen_d;
  logic [N_CH-1:0]            en_q, en_d;
  logic [N_CH-1:0][SEL_W-1:0] sel_q, sel_d;
  logic [N_MT-1:0][MT_W-1:0]  mtl_q, mtl_d;
  logic [N_CH-1:0][CNT_W-1:0] chl_q, chl_d;

  // write decode: next-state
  always_comb begin
    gen_d = gen_q;
    en_d  = en_q;
    sel_d = sel_q;
    mtl_d = mtl_q;
    chl_d = chl_q;
    if (addr == A_CTRL)   gen_d = wdata[0];
    if (addr == A_CH_EN)  en_d  = wdata[N_CH-1:0];
    if (addr == A_MT_SEL) sel_d = wdata[N_CH*SEL_W-1:0];
    for (int m = 0; m < N_MT; m++)
      if (addr == ADDR_W'(int'(A_MT_LOAD) + m)) mtl_d[m] = wdata[MT_W-1:0];
    for (int c = 0; c < N_CH; c++)
      if (addr == ADDR_W'(int'(A_CH_LOAD) + c)) chl_d[c] = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= 1'b0;
      en_q  <= '0;
      sel_q <= '0;
      mtl_q <= '0;
      chl_q <= '0;
    end else if (wr_en) begin
      gen_q <= gen_d;
      en_q  <= en_d;
      sel_q <= sel_d;
      mtl_q <= mtl_d;
      chl_q <= chl_d;
    end
  end

  // single-cycle strobes
  always_comb begin
    for (int m = 0; m < N_MT; m++)
      mt_force[m] = wr_en && (addr == A_FORCE) && wdata[FORCE_MT_LSB + m];
    for (int c = 0; c < N_CH; c++) begin
      ch_force[c] = wr_en && (addr == A_FORCE) && wdata[c];
      flag_clr[c] = wr_en && (addr == A_FLAGS) && wdata[c];
    end
  end

  // read mux; restart register reads zero
  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)   rdata[0] = gen_q;
    if (addr == A_CH_EN)  rdata[N_CH-1:0] = en_q;
    if (addr == A_MT_SEL) rdata[N_CH*SEL_W-1:0] = sel_q;
    if (addr == A_FLAGS)  rdata[N_CH-1:0] = flags;
    for (int m = 0; m < N_MT; m++)
      if (addr == ADDR_W'(int'(A_MT_LOAD) + m)) rdata[MT_W-1:0] = mtl_q[m];
    for (int c = 0; c < N_CH; c++) begin
      if (addr == ADDR_W'(int'(A_CH_LOAD) + c)) rdata[CNT_W-1:0] = chl_q[c];
      if (addr == ADDR_W'(int'(A_CH_CNT) + c))  rdata[CNT_W-1:0] = ch_cnt[c];
    end
  end

  assign gen_en  = gen_q;
  assign ch_en   = en_q;
  assign ch_sel  = sel_q;
  assign mt_load = mtl_q;
  assign ch_load = chl_q;
endmodule

// File: rtl/ct_micro.sv
module ct_micro #(
  parameter int MT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            force_ld,
  input  logic [MT_W-1:0] load,
  output logic            tick
);
  logic [MT_W-1:0] cnt_q, cnt_d;
  logic            zero;

  assign zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (force_ld) begin
      cnt_d = load;
    end else if (run) begin
      tick  = zero;
      cnt_d = zero ? load : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (force_ld || run) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ct_channel.sv
module ct_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             force_ld,
  input  logic             clr,
  input  logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             trig
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             trig_q;
  logic             step, expire;

  assign step   = run && tick && !force_ld;
  assign expire = step && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (force_ld)  cnt_d = load;
    else if (step) cnt_d = expire ? load : cnt_q - 1'b1;
    // set has priority over a same-edge clear
    flag_d = expire ? 1'b1 : (clr ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (force_ld || step) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      trig_q <= expire;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
  assign trig = trig_q;
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int N_MT  = 2,
  parameter int MT_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [N_CH-1:0]   trig_o
);
  localparam int SEL_W = (N_MT > 1) ? $clog2(N_MT) : 1;

  logic [1:0]                 rst_sync;
  logic                       rst_sync_n;
  logic                       gen_en;
  logic [N_CH-1:0]            ch_en;
  logic [N_CH-1:0][SEL_W-1:0] ch_sel;
  logic [N_MT-1:0][MT_W-1:0]  mt_load;
  logic [N_CH-1:0][CNT_W-1:0] ch_load;
  logic [N_MT-1:0]            mt_force;
  logic [N_CH-1:0]            ch_force;
  logic [N_CH-1:0]            flag_clr;
  logic [N_CH-1:0]            flags;
  logic [N_CH-1:0][CNT_W-1:0] ch_cnt;
  logic [N_MT-1:0]            mt_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  ct_regs #(.N_CH(N_CH), .N_MT(N_MT), .MT_W(MT_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .gen_en(gen_en), .ch_en(ch_en), .ch_sel(ch_sel),
    .mt_load(mt_load), .ch_load(ch_load),
    .mt_force(mt_force), .ch_force(ch_force), .flag_clr(flag_clr),
    .flags(flags), .ch_cnt(ch_cnt)
  );

  for (genvar m = 0; m < N_MT; m++) begin : g_mt
    ct_micro #(.MT_W(MT_W)) u_mt (
      .clk(clk), .rst_n(rst_sync_n), .run(gen_en),
      .force_ld(mt_force[m]), .load(mt_load[m]), .tick(mt_tick[m])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_sync_n),
      .run(gen_en && ch_en[c]), .tick(mt_tick[ch_sel[c]]),
      .force_ld(ch_force[c]), .clr(flag_clr[c]), .load(ch_load[c]),
      .cnt(ch_cnt[c]), .flag(flags[c]), .trig(trig_o[c])
    );
  end
endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk
  import cascade_timer_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int CNT_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       gen_en,
  input logic [N_CH-1:0]            ch_en,
  input logic [N_CH-1:0]            ch_force,
  input logic [N_CH-1:0]            flag_clr,
  input logic [N_CH-1:0][CNT_W-1:0] ch_load,
  input logic [N_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic [N_CH-1:0]            flags,
  input logic [N_CH-1:0]            trig,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [BUS_W-1:0]           bus_rdata
);
  for (genvar c = 0; c < N_CH; c++) begin : g_prop
    assert_trig_has_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trig[c] |-> flags[c]);
    assert_flag_rise_on_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[c]) |-> trig[c]);
    assert_flag_fall_needs_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[c]) |-> $past(flag_clr[c]));
    assert_restart_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ch_force[c] |=> ch_cnt[c] == $past(ch_load[c]));
    assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((!gen_en || !ch_en[c]) && !ch_force[c]) |=> ($stable(ch_cnt[c]) && !trig[c]));
  end

  assert_restart_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_FORCE) |-> (bus_rdata == '0));
endmodule

bind cascade_timer cascade_timer_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .gen_en(gen_en), .ch_en(ch_en),
  .ch_force(ch_force), .flag_clr(flag_clr), .ch_load(ch_load), .ch_cnt(ch_cnt),
  .flags(flags), .trig(trig_o), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/cascade_timer_bench.sv
module cascade_timer_bench;
  import cascade_timer_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [BUS_W-1:0]  bus_wdata;
  logic [BUS_W-1:0]  bus_rdata;
  logic [3:0]        trig_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  cascade_timer u_cascade_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_o(trig_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [ADDR_W-1:0] a, input int d);
    bus_addr  = a;
    bus_wdata = BUS_W'(d);
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output int d);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
  endtask

  // clocks until the next trigger on channel c
  task automatic measure(input int c, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!trig_o[c] && n < 5000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int v, n, p;
    int mlist[8] = '{0, 0, 2, 3, 1, 5, 0, 4};
    int llist[8] = '{0, 3, 0, 2, 5, 1, 1, 4};
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    for (int c = 0; c < 4; c++) begin
      rd(A_CH_CNT + 5'(c), v);  check(v == 0, "R11 count", v, 0);
      rd(A_CH_LOAD + 5'(c), v); check(v == 0, "R11 load", v, 0);
    end
    rd(A_FLAGS, v); check(v == 0, "R11 flags", v, 0);
    rd(A_CH_EN, v); check(v == 0, "R11 enables", v, 0);
    check(trig_o == 0, "R11 trig", int'(trig_o), 0);

    // R1/R2 interval sweep over load pairs, channels and micro timers
    for (int i = 0; i < 8; i++) begin
      int c = i % 4;
      int m = i % 2;
      wr(A_CTRL, 0);
      wr(A_MT_LOAD + 5'(m), mlist[i]);
      wr(A_MT_LOAD + 5'(1 - m), 7);
      wr(A_CH_LOAD + 5'(c), llist[i]);
      wr(A_CH_EN, 1 << c);
      wr(A_MT_SEL, (m == 1) ? 'hF : 0);
      wr(A_CTRL, 1);
      wr(A_FORCE, 'h030F);
      p = (mlist[i] + 1) * (llist[i] + 1);
      measure(c, n); check(n == p, "R1 first interval after restart (R8)", n, p);
      measure(c, n); check(n == p, "R1 R2 repeat interval", n, p);
      if (p > 1) begin
        @(negedge clk);
        check(trig_o[c] == 1'b0, "R4 pulse one cycle", int'(trig_o[c]), 0);
      end
    end

    // R3 count readback: Lm=1, Lc=3
    wr(A_CTRL, 0);
    wr(A_MT_LOAD, 1); wr(A_CH_LOAD, 3); wr(A_CH_EN, 1); wr(A_MT_SEL, 0);
    wr(A_CTRL, 1);
    wr(A_FORCE, 'h0101);
    rd(A_CH_CNT, v); check(v == 3, "R7 count after restart", v, 3);
    repeat (2) @(negedge clk);
    rd(A_CH_CNT, v); check(v == 2, "R3 first step", v, 2);
    repeat (4) @(negedge clk);
    rd(A_CH_CNT, v); check(v == 0, "R3 at zero", v, 0);
    repeat (2) @(negedge clk);
    rd(A_CH_CNT, v); check(v == 3, "R3 reload", v, 3);
    check(trig_o[0] == 1'b1, "R4 trigger at reload", int'(trig_o[0]), 1);
    rd(A_FLAGS, v); check(v[0] == 1'b1, "R4 flag with trigger", v & 1, 1);

    // R5 clear semantics with counting stopped
    wr(A_CTRL, 0);
    wr(A_FLAGS, 0);
    rd(A_FLAGS, v); check(v[0] == 1'b1, "R5 write zero keeps flag", v & 1, 1);
    wr(A_FLAGS, 1);
    rd(A_FLAGS, v); check(v[0] == 1'b0, "R5 write one clears", v & 1, 0);

    // R6 set wins: every edge is a time-out with both loads 0
    wr(A_MT_LOAD, 0); wr(A_CH_LOAD, 0);
    wr(A_CTRL, 1);
    wr(A_FORCE, 'h0101);
    wr(A_FLAGS, 1);
    rd(A_FLAGS, v); check(v[0] == 1'b1, "R6 set beats clear", v & 1, 1);

    // R7 mid-interval restart of both stages: Lm=3, Lc=2
    wr(A_CTRL, 0);
    wr(A_MT_LOAD, 3); wr(A_CH_LOAD, 2);
    wr(A_CTRL, 1);
    wr(A_FORCE, 'h0101);
    repeat (5) @(negedge clk);
    wr(A_FORCE, 'h0101);
    measure(0, n); check(n == 12, "R7 full interval after restart", n, 12);

    // R8 prescaler-only restart: Lm=3, Lc=0
    wr(A_CTRL, 0);
    wr(A_CH_LOAD, 0);
    wr(A_CTRL, 1);
    wr(A_FORCE, 'h0101);
    @(negedge clk);
    wr(A_FORCE, 'h0100);
    measure(0, n); check(n == 4, "R8 micro restart alone", n, 4);

    // R9
    rd(A_FORCE, v); check(v == 0, "R9 restart reads zero", v, 0);

    // R10 global run off, then channel enable off
    wr(A_CTRL, 0);
    wr(A_FLAGS, 'hF);
    wr(A_MT_LOAD, 0); wr(A_CH_LOAD, 5); wr(A_CH_LOAD + 5'd1, 3);
    wr(A_CH_EN, 1); wr(A_MT_SEL, 0);
    wr(A_FORCE, 'h0103);
    n = 0;
    repeat (10) begin @(negedge clk); if (trig_o[0]) n++; end
    check(n == 0, "R10 no trigger when run off", n, 0);
    rd(A_CH_CNT, v); check(v == 5, "R10 count held when run off", v, 5);
    wr(A_CH_EN, 2);
    wr(A_CTRL, 1);
    wr(A_FORCE, 'h0103);
    n = 0;
    repeat (10) begin @(negedge clk); if (trig_o[0]) n++; end
    check(n == 0, "R10 no trigger when channel off", n, 0);
    rd(A_CH_CNT, v); check(v == 5, "R10 count held when channel off", v, 5);
    rd(A_FLAGS, v); check(v == 2, "R10 only enabled channel flags", v, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule